// File: doc/BRIEF.md
# Guarded Control Register with Write Protection

This block keeps the one-byte configuration word of a serial memory supervisor. The word holds a timeout selection, a three-bit block-protect code and a hardware-lock enable. These fields are treated as persistent and are modelled as flops that reset to a parameter value. Two volatile latches, a write-enable latch and a register-unlock latch, gate every change. A bus front end hands the block one data byte per register write and then signals either the end of the transfer or an abort. The block answers each byte with an acknowledge or a refusal.

A persistent update is applied only after a fixed unlock order of three single-byte writes. A hardware-lock pin, together with the lock-enable bit, can refuse that update. After each persistent update the block reports busy for a parameterised number of cycles. The block also decodes the protect code into a protected address range of the memory array. For any array address it says whether a write may proceed. An attempted write into a protected range drops the unlock latch.

Top module: `guarded_ctrl_reg`

## Requirements
- R1: After reset, `reg_value` equals `NV_RESET` with both latches clear (default 60h), `busy` is low and `wr_ack` is low.
- R2: A transfer whose single byte is 02h sets the write-enable latch (bit 1) when the unlock latch is clear. No busy period follows.
- R3: A single byte 06h sets the unlock latch (bit 2) only when bit 1 is already set. No busy period follows. The unlock latch is never set while bit 1 is clear.
- R4: While bit 1 is clear, any byte other than 02h is refused (`wr_ack` low in the cycle after the byte) and changes nothing.
- R5: With both latches set and a byte whose bit 2 is 0, the persistent fields are loaded. WPEN comes from bit 7, the timeout selection from bits 6:5, and the protect code {bp2,bp1,bp0} from bits {0,4,3}. The unlock latch clears, bit 1 stays set, and `busy` is high for exactly `NV_CYCLES` cycles.
- R6: With both latches set and a byte whose bit 2 is 1, the persistent fields are unchanged and the unlock latch stays set.
- R7: With the unlock latch clear and bit 1 set, a byte 00h clears bit 1.
- R8: While `busy` is high, every byte is refused and the register does not change.
- R9: A second byte within one transfer is refused, and that transfer then changes nothing at its end.
- R10: An abort discards the pending byte, so the register does not change.
- R11: The protect code selects the blocked range of an array of 2^ADDR_W bytes. The codes are: 000 none; 001 upper quarter; 010 upper half; 011 whole array; 100, 101, 110 and 111 the lowest 1, 2, 4 and 8 pages of `PAGE_BYTES`.
- R12: When `wp_pin` and WPEN (bit 7) are both high, the persistent update of R5 is refused and changes nothing. The latch writes of R2 and R6 still succeed.
- R13: An array write attempt (`arr_wr`) to a protected address clears the unlock latch.
- R14: `arr_allow` is high only when bit 1 is set and the address lies outside the protected range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One data byte of a register write is present |
| wr_data | input | 8 | The data byte |
| wr_end | input | 1 | Transfer completed normally; apply the pending byte |
| wr_abort | input | 1 | Transfer broken off; discard the pending byte |
| wr_ack | output | 1 | Acknowledge for the byte of the previous cycle |
| wp_pin | input | 1 | Hardware write-lock pin |
| arr_addr | input | ADDR_W | Array address being queried |
| arr_wr | input | 1 | An array write to `arr_addr` is being attempted |
| arr_allow | output | 1 | Array write to `arr_addr` is permitted |
| busy | output | 1 | Persistent update cycle in progress |
| reg_value | output | 8 | Current register image {WPEN,WD1,WD0,BP1,BP0,RWEL,WEL,BP2} |

## Verification
The case hardest to reach from the ports is a byte arriving while the persistent cycle is still running. It needs the full unlock order to be completed first, and then a new transfer issued at once, before the busy window closes. The stimulus walks a table that drives the register through several unlock orders, including the hardware-locked refusal. Directed steps then fire a write immediately after a commit, send a two-byte transfer, and issue a protected array write between the unlock step and the commit.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

    localparam logic [7:0] CODE_SET_WEL  = 8'h02;
    localparam logic [7:0] CODE_SET_RWEL = 8'h06;
    localparam logic [7:0] CODE_CLEAR    = 8'h00;
    localparam int         KEEP_BIT      = 2;

    typedef enum logic [1:0] {
        CNT_NONE = 2'd0,
        CNT_ONE  = 2'd1,
        CNT_MANY = 2'd2
    } byte_cnt_e;

    typedef struct packed {
        logic       wel;
        logic       rwel;
        logic       wpen;
        logic [1:0] wd;
        logic [2:0] bp;
        byte_cnt_e  nbytes;
        logic [7:0] pend;
        logic       pend_ok;
        logic       ack;
    } gcr_state_t;

endpackage

// File: rtl/gcr_prot_decode.sv
module gcr_prot_decode #(
    parameter int ADDR_W     = 13,
    parameter int PAGE_BYTES = 64
) (
    input  logic [2:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int LIM_W = ADDR_W + 1;
    localparam logic [LIM_W-1:0] PAGE_LIM = LIM_W'(PAGE_BYTES);

    logic [LIM_W-1:0] low_limit;
    logic             upper_q;
    logic             upper_h;

    assign low_limit = PAGE_LIM << bp[1:0];
    assign upper_h   = addr[ADDR_W-1];

    generate
        if (ADDR_W >= 2) begin : g_quarter
            assign upper_q = &addr[ADDR_W-1:ADDR_W-2];
        end else begin : g_tiny
            assign upper_q = addr[ADDR_W-1];
        end
    endgenerate

    always_comb begin
        unique case (bp)
            3'b000:  hit = 1'b0;
            3'b001:  hit = upper_q;
            3'b010:  hit = upper_h;
            3'b011:  hit = 1'b1;
            default: hit = ({1'b0, addr} < low_limit);
        endcase
    end
endmodule

// File: rtl/gcr_nv_timer.sv
module gcr_nv_timer #(
    parameter int NV_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(NV_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(NV_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/guarded_ctrl_reg.sv
module guarded_ctrl_reg
    import gcr_pkg::*;
#(
    parameter int         ADDR_W     = 13,
    parameter int         PAGE_BYTES = 64,
    parameter int         NV_CYCLES  = 20,
    parameter logic [7:0] NV_RESET   = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              wr_end,
    input  logic              wr_abort,
    output logic              wr_ack,
    input  logic              wp_pin,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              arr_wr,
    output logic              arr_allow,
    output logic              busy,
    output logic [7:0]        reg_value
);
    gcr_state_t s_d, s_q;
    logic       nv_start;
    logic       prot_hit;
    logic       hw_lock;
    logic       accept;

    gcr_prot_decode #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_decode (
        .bp   (s_q.bp),
        .addr (arr_addr),
        .hit  (prot_hit)
    );

    gcr_nv_timer #(
        .NV_CYCLES (NV_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .busy  (busy)
    );

    assign hw_lock = wp_pin & s_q.wpen;

    // Byte acceptance: refused while busy, when locked out by the write
    // latch, or when the hardware lock forbids the persistent update.
    always_comb begin
        accept = !busy && (s_q.wel || wr_data == CODE_SET_WEL);
        if (s_q.wel && s_q.rwel && !wr_data[KEEP_BIT] && hw_lock) begin
            accept = 1'b0;
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.ack  = 1'b0;
        nv_start = 1'b0;

        if (wr_abort) begin
            s_d.nbytes  = CNT_NONE;
            s_d.pend_ok = 1'b0;
        end else if (wr_end) begin
            if (s_q.nbytes == CNT_ONE && s_q.pend_ok && !busy) begin
                if (s_q.wel && s_q.rwel) begin
                    if (!s_q.pend[KEEP_BIT] && !hw_lock) begin
                        s_d.wpen = s_q.pend[7];
                        s_d.wd   = s_q.pend[6:5];
                        s_d.bp   = {s_q.pend[0], s_q.pend[4], s_q.pend[3]};
                        s_d.rwel = 1'b0;
                        nv_start = 1'b1;
                    end
                end else if (s_q.pend == CODE_SET_WEL) begin
                    s_d.wel = 1'b1;
                end else if (s_q.pend == CODE_SET_RWEL && s_q.wel) begin
                    s_d.rwel = 1'b1;
                end else if (s_q.pend == CODE_CLEAR && s_q.wel) begin
                    s_d.wel  = 1'b0;
                    s_d.rwel = 1'b0;
                end
            end
            s_d.nbytes  = CNT_NONE;
            s_d.pend_ok = 1'b0;
        end else if (wr_valid) begin
            if (s_q.nbytes == CNT_NONE) begin
                s_d.pend    = wr_data;
                s_d.pend_ok = accept;
                s_d.ack     = accept;
                s_d.nbytes  = CNT_ONE;
            end else begin
                s_d.nbytes  = CNT_MANY;
                s_d.pend_ok = 1'b0;
            end
        end

        // A write aimed at a protected block drops the unlock latch.
        if (arr_wr && prot_hit) begin
            s_d.rwel = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.wpen    <= NV_RESET[7];
            s_q.wd      <= NV_RESET[6:5];
            s_q.bp      <= {NV_RESET[0], NV_RESET[4], NV_RESET[3]};
            s_q.nbytes  <= CNT_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_ack    = s_q.ack;
    assign arr_allow = s_q.wel & ~prot_hit;
    assign reg_value = {s_q.wpen, s_q.wd, s_q.bp[1], s_q.bp[0],
                        s_q.rwel, s_q.wel, s_q.bp[2]};
endmodule

// File: rtl/guarded_ctrl_reg_chk.sv
module guarded_ctrl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic [7:0] wr_data,
    input logic       wr_ack,
    input logic       arr_wr,
    input logic       arr_allow,
    input logic       busy,
    input logic [7:0] reg_value
);
    p_rwel_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_value[2] |-> reg_value[1]);

    p_nack_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !reg_value[1] && wr_data != 8'h02) |=> !wr_ack);

    p_commit_drops_rwel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !reg_value[2]);

    p_busy_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({reg_value[7:3], reg_value[0]}));

    p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_valid) |=> !wr_ack);

    p_full_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_value[4:3] == 2'b11 && !reg_value[0]) |-> !arr_allow);

    p_prot_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr && reg_value[1] && !arr_allow) |=> !reg_value[2]);

    p_allow_needs_wel_r14: assert property (@(posedge clk) disable iff (!rst_n)
        arr_allow |-> reg_value[1]);
endmodule

bind guarded_ctrl_reg guarded_ctrl_reg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_ack    (wr_ack),
    .arr_wr    (arr_wr),
    .arr_allow (arr_allow),
    .busy      (busy),
    .reg_value (reg_value)
);

// File: tb/guarded_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module guarded_ctrl_reg_tb_top;
    localparam int ADDR_W = 13;
    localparam int NV_CYC = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [7:0]        wr_data = '0;
    logic              wr_end = 1'b0;
    logic              wr_abort = 1'b0;
    logic              wr_ack;
    logic              wp_pin = 1'b0;
    logic [ADDR_W-1:0] arr_addr = '0;
    logic              arr_wr = 1'b0;
    logic              arr_allow;
    logic              busy;
    logic [7:0]        reg_value;

    int  n_vec = 0;
    int  n_mis = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    guarded_ctrl_reg #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (64),
        .NV_CYCLES  (NV_CYC),
        .NV_RESET   (8'h60)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_end    (wr_end),
        .wr_abort  (wr_abort),
        .wr_ack    (wr_ack),
        .wp_pin    (wp_pin),
        .arr_addr  (arr_addr),
        .arr_wr    (arr_wr),
        .arr_allow (arr_allow),
        .busy      (busy),
        .reg_value (reg_value)
    );

    // {wp, byte, expected ack, expected register after the transfer}
    localparam int NV = 16;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 8'h06, 1'b0, 8'h60},  // R3/R4: unlock without WEL refused
        {1'b0, 8'h02, 1'b1, 8'h62},  // R2
        {1'b0, 8'h06, 1'b1, 8'h66},  // R3
        {1'b0, 8'h06, 1'b1, 8'h66},  // R6: bit2 set keeps fields
        {1'b0, 8'h02, 1'b1, 8'h02},  // R5: 02,06,02 clears fields
        {1'b0, 8'h06, 1'b1, 8'h06},  // R3
        {1'b0, 8'h06, 1'b1, 8'h06},  // R6
        {1'b0, 8'hB2, 1'b1, 8'hB2},  // R5: field mapping
        {1'b0, 8'h00, 1'b1, 8'hB0},  // R7
        {1'b0, 8'h45, 1'b0, 8'hB0},  // R4
        {1'b0, 8'h02, 1'b1, 8'hB2},  // R2
        {1'b0, 8'h06, 1'b1, 8'hB6},  // R3
        {1'b1, 8'h02, 1'b0, 8'hB6},  // R12: hardware lock refuses update
        {1'b1, 8'h06, 1'b1, 8'hB6},  // R12: keep-write still accepted
        {1'b0, 8'h61, 1'b1, 8'h63},  // R5: bp2 from bit 0
        {1'b0, 8'h00, 1'b1, 8'h61}   // R7
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_mis++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] b, output logic ack);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
        ack      = wr_ack;
        wr_end   = 1'b1;
        @(negedge clk);
        wr_end   = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic probe(input string tag, input logic [ADDR_W-1:0] a, input logic exp);
        arr_addr = a;
        #1;
        check(tag, {7'd0, arr_allow}, {7'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_mis++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
            $finish;
        end
    end

    initial begin
        logic a;
        int   cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reg", reg_value, 8'h60);
        check("R1 busy", {7'd0, busy}, 8'h00);
        check("R1 ack", {7'd0, wr_ack}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            wp_pin = VEC[i][17];
            do_write(VEC[i][16:9], a);
            check($sformatf("vec%0d ack", i), {7'd0, a}, {7'd0, VEC[i][8]});
            check($sformatf("vec%0d reg", i), reg_value, VEC[i][7:0]);
            wait_idle();
        end
        wp_pin = 1'b0;

        // R14: no WEL, no array write
        probe("R14 wel clear", 13'h1000, 1'b0);
        do_write(8'h02, a);
        check("R2 reg", reg_value, 8'h63);
        // R11: code 100, first page
        probe("R11 p1 in", 13'h003F, 1'b0);
        probe("R11 p1 out", 13'h0040, 1'b1);

        // R13: protected array write drops RWEL
        do_write(8'h06, a);
        check("R13 pre", reg_value, 8'h67);
        @(negedge clk);
        arr_addr = 13'h0010;
        arr_wr   = 1'b1;
        @(negedge clk);
        arr_wr   = 1'b0;
        check("R13 rwel", reg_value, 8'h63);

        // R5: busy length, code 001
        do_write(8'h06, a);
        do_write(8'h0A, a);
        check("R5 reg", reg_value, 8'h0A);
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        check("R5 busy len", 8'(cnt), 8'(NV_CYC));
        probe("R11 q4 out", 13'h17FF, 1'b1);
        probe("R11 q4 in", 13'h1800, 1'b0);

        // R8: byte during busy
        do_write(8'h06, a);
        do_write(8'h1A, a);
        check("R11 reg", reg_value, 8'h1A);
        do_write(8'h06, a);
        check("R8 ack", {7'd0, a}, 8'h00);
        check("R8 reg", reg_value, 8'h1A);
        wait_idle();
        probe("R11 all lo", 13'h0000, 1'b0);
        probe("R11 all hi", 13'h1FFF, 1'b0);

        // R9: two bytes in one transfer
        @(negedge clk);
        wr_valid = 1'b1; wr_data = 8'h06;
        @(negedge clk);
        check("R9 first ack", {7'd0, wr_ack}, 8'h01);
        wr_data = 8'h06;
        @(negedge clk);
        wr_valid = 1'b0;
        check("R9 second ack", {7'd0, wr_ack}, 8'h00);
        wr_end = 1'b1;
        @(negedge clk);
        wr_end = 1'b0;
        check("R9 reg", reg_value, 8'h1A);

        // R10: abort
        @(negedge clk);
        wr_valid = 1'b1; wr_data = 8'h06;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_abort = 1'b1;
        @(negedge clk);
        wr_abort = 1'b0;
        wr_end   = 1'b1;
        @(negedge clk);
        wr_end   = 1'b0;
        check("R10 reg", reg_value, 8'h1A);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
        $finish;
    end
endmodule